// File: doc/BRIEF.md
# Trail Trace Identifier Capture Buffer

This block collects the 64-byte trail trace identifier that the receive side delivers one byte per frame from the section monitoring overhead. Each byte comes with the multiframe position (the alignment count modulo 64) of the frame it came from. That position is the byte's index. Bytes are packed two to a 16-bit word into a 32-word store. The store is rewritten continuously, so each new 64-frame multiframe replaces the one before it.

A processor reaches the store through two addresses: a data address and a configuration address. One 5-bit pointer, held in the configuration word, selects the store word for both reads and writes. The pointer advances by one after every data access. The configuration word also holds three controls. The first is an invalidate bit: setting it from 0 to 1 drops the three live flags. The other two force the backward error indication sent on the transmit side to the incoming-alignment-error code, either always or only while an alignment error is being detected.

The byte input is a valid/ready stream. Ready is held high at all times, because the store takes a byte every cycle and never back-pressures. A byte is accepted in every cycle where valid is high.

Top module: `tti_capture_buf`

## Requirements
- R1: After reset, a configuration read returns 0x0000, `tti_live` is 3'b000, and `bei_out` equals `bei_in`.
- R2: An accepted byte whose index n = `ov_mfas` is placed in store word n>>1. It goes in bits 7:0 when n is even and in bits 15:8 when n is odd.
- R3: Capture runs continuously. A byte received for an index replaces whatever that index held before.
- R4: A processor read (`cpu_req`=1, `cpu_we`=0) raises `cpu_rvalid` one cycle later. In that cycle `cpu_rdata` holds either the store word at the pointer (`cpu_sel_cfg`=0) or the configuration word (`cpu_sel_cfg`=1).
- R5: Every data-address access, read or write, increments the pointer by one, wrapping from 31 to 0. A configuration write loads the pointer from bits 12:8.
- R6: A data-address write stores all 16 bits of `cpu_wdata` in the word at the pointer.
- R7: The configuration word has the pointer in bits 12:8, invalidate in bit 7, auto-BIAE in bit 5 and manual-BIAE in bit 4. Bits 15:13, 6 and 3:0 always read 0.
- R8: A configuration write that moves the invalidate bit from 0 to 1 clears `tti_live` on the next cycle. Writing 1 while the bit is already 1 leaves `tti_live` unchanged.
- R9: `tti_live` becomes 3'b111 when bytes with indices 0 through 63 are accepted in unbroken sequence with no invalidate in between. If an index is skipped, the flags stay as they were.
- R10: With auto-BIAE set, `bei_out` is 4'b1011 while `iae_det` is 1 and equals `bei_in` while it is 0. With auto-BIAE clear, `iae_det` has no effect.
- R11: With manual-BIAE set, `bei_out` is 4'b1011 whatever the value of `iae_det`.
- R12: If a received byte and a processor data write hit the same word in the same cycle, the received byte wins its half and the processor value fills the other half.
- R13: `ov_ready` is 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ov_valid | input | 1 | Received byte valid |
| ov_ready | output | 1 | Byte acceptance, always high |
| ov_byte | input | 8 | Received identifier byte |
| ov_mfas | input | 6 | Multiframe position of the byte, modulo 64 |
| cpu_req | input | 1 | Processor access strobe, one cycle |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_sel_cfg | input | 1 | 1 selects the configuration address, 0 selects the data address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cpu_rdata | output | 16 | Read data |
| iae_det | input | 1 | Incoming alignment error detected |
| bei_in | input | 4 | Backward error indication from the error counter |
| bei_out | output | 4 | Backward error indication to the transmit overhead |
| tti_live | output | 3 | Identifier field live flags |

## Verification
A wrong pointer value shows up on the next data read as a word from a neighbouring index, or when the pointer is read back through the configuration address. A misrouted byte lane shows up when the store is read after one full multiframe, so each run uses byte patterns in which every index carries a distinct value. Errors in the run tracker that drives the live flags appear only at the end of a multiframe. For that reason, invalidates, gaps and repeated invalidate writes are each followed by a complete 64-byte pass before the flags are checked. A wrong BIAE control appears on `bei_out` in the cycle after the configuration write.

// File: rtl/tti_pkg.sv
package tti_pkg;
  localparam int unsigned TTI_BYTES    = 64;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned IDX_W        = $clog2(TTI_BYTES);
  localparam int unsigned WORD_W       = 2 * BYTE_W;
  localparam int unsigned DEPTH        = TTI_BYTES / 2;
  localparam int unsigned WA_W         = $clog2(DEPTH);
  localparam int unsigned BEI_W        = 4;
  localparam int unsigned LIVE_N       = 3;
  localparam logic [BEI_W-1:0] BIAE_CODE = 4'b1011;
  localparam int unsigned CFG_PTR_LSB  = 8;
  localparam int unsigned CFG_INV_BIT  = 7;
  localparam int unsigned CFG_AUTO_BIT = 5;
  localparam int unsigned CFG_MANU_BIT = 4;

  typedef struct packed {
    logic              we;
    logic [WA_W-1:0]   word;
    logic              half;
    logic [BYTE_W-1:0] data;
  } cap_wr_t;
endpackage

// File: rtl/tti_rx_writer.sv
module tti_rx_writer
  import tti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ov_valid,
  input  logic [BYTE_W-1:0] ov_byte,
  input  logic [IDX_W-1:0]  ov_mfas,
  input  logic              inv_pulse,
  output cap_wr_t           cap,
  output logic [LIVE_N-1:0] live
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TTI_BYTES - 1);

  logic             run_q;
  logic [IDX_W-1:0] exp_q;
  logic [LIVE_N-1:0] live_q;

  always_comb begin
    cap.we   = ov_valid;
    cap.word = ov_mfas[IDX_W-1:1];
    cap.half = ov_mfas[0];
    cap.data = ov_byte;
  end

  // Run tracker: a run starts at index 0 and must continue in steps of one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      exp_q  <= '0;
      live_q <= '0;
    end else if (inv_pulse) begin
      run_q  <= 1'b0;
      live_q <= '0;
    end else if (ov_valid) begin
      if (ov_mfas == '0) begin
        run_q <= 1'b1;
        exp_q <= IDX_W'(1);
      end else if (run_q && ov_mfas == exp_q) begin
        exp_q <= exp_q + 1'b1;
        if (ov_mfas == LAST_IDX) begin
          live_q <= '1;
          run_q  <= 1'b0;
        end
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign live = live_q;

  p_live_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> (live == '0));

  p_live_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live[0]) |-> ($past(ov_valid) && $past(ov_mfas) == LAST_IDX));
endmodule

// File: rtl/tti_word_store.sv
module tti_word_store
  import tti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cap_wr_t           cap,
  input  logic              cpu_wr_en,
  input  logic [WA_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] rd_word
);
  logic [BYTE_W-1:0] lo_q [DEPTH];
  logic [BYTE_W-1:0] hi_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic cpu_hit, cap_lo, cap_hi;
    assign cpu_hit = cpu_wr_en && (cpu_addr == WA_W'(g));
    assign cap_lo  = cap.we && (cap.word == WA_W'(g)) && !cap.half;
    assign cap_hi  = cap.we && (cap.word == WA_W'(g)) &&  cap.half;

    // Received byte takes its half; processor value fills the rest.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else begin
        if (cap_lo)       lo_q[g] <= cap.data;
        else if (cpu_hit) lo_q[g] <= cpu_wdata[BYTE_W-1:0];
        if (cap_hi)       hi_q[g] <= cap.data;
        else if (cpu_hit) hi_q[g] <= cpu_wdata[WORD_W-1:BYTE_W];
      end
    end
  end

  assign rd_word = {hi_q[cpu_addr], lo_q[cpu_addr]};

  p_cap_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap.we |=> ($past(cap.half) ? hi_q[$past(cap.word)] : lo_q[$past(cap.word)])
               == $past(cap.data));
endmodule

// File: rtl/tti_cpu_regs.sv
module tti_cpu_regs
  import tti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_sel_cfg,
  input  logic [WA_W-1:0]   wr_ptr,
  input  logic              wr_inv,
  input  logic              wr_auto,
  input  logic              wr_manu,
  input  logic [WORD_W-1:0] mem_rd_word,
  output logic [WA_W-1:0]   ptr,
  output logic              inv_pulse,
  output logic              auto_en,
  output logic              manu_en,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata
);
  logic [WA_W-1:0]   ptr_q;
  logic              inv_q, auto_q, manu_q, rvalid_q;
  logic [WORD_W-1:0] rdata_q, cfg_word;
  logic              data_acc, cfg_wr, rd_req;

  assign data_acc  = cpu_req && !cpu_sel_cfg;
  assign cfg_wr    = cpu_req && cpu_we && cpu_sel_cfg;
  assign rd_req    = cpu_req && !cpu_we;
  assign inv_pulse = cfg_wr && wr_inv && !inv_q;

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_PTR_LSB +: WA_W] = ptr_q;
    cfg_word[CFG_INV_BIT]  = inv_q;
    cfg_word[CFG_AUTO_BIT] = auto_q;
    cfg_word[CFG_MANU_BIT] = manu_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      inv_q  <= 1'b0;
      auto_q <= 1'b0;
      manu_q <= 1'b0;
    end else if (cfg_wr) begin
      ptr_q  <= wr_ptr;
      inv_q  <= wr_inv;
      auto_q <= wr_auto;
      manu_q <= wr_manu;
    end else if (data_acc) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= cpu_sel_cfg ? cfg_word : mem_rd_word;
    end
  end

  assign ptr        = ptr_q;
  assign auto_en    = auto_q;
  assign manu_en    = manu_q;
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (ptr_q == $past(ptr_q) + 1'b1));

  p_ptr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (ptr_q == $past(wr_ptr)));

  p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> cpu_rvalid);
endmodule

// File: rtl/tti_capture_buf.sv
module tti_capture_buf
  import tti_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ov_valid,
  output logic                 ov_ready,
  input  logic [BYTE_W-1:0]    ov_byte,
  input  logic [IDX_W-1:0]     ov_mfas,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic                 cpu_sel_cfg,
  input  logic [WORD_W-1:0]    cpu_wdata,
  output logic                 cpu_rvalid,
  output logic [WORD_W-1:0]    cpu_rdata,
  input  logic                 iae_det,
  input  logic [BEI_W-1:0]     bei_in,
  output logic [BEI_W-1:0]     bei_out,
  output logic [LIVE_N-1:0]    tti_live
);
  cap_wr_t           cap;
  logic [WA_W-1:0]   ptr;
  logic              inv_pulse, auto_en, manu_en, force_biae;
  logic [WORD_W-1:0] mem_rd_word;

  assign ov_ready = 1'b1;

  tti_rx_writer u_writer (
    .clk, .rst_n, .ov_valid, .ov_byte, .ov_mfas,
    .inv_pulse, .cap, .live(tti_live)
  );

  tti_word_store u_store (
    .clk, .rst_n, .cap,
    .cpu_wr_en (cpu_req && cpu_we && !cpu_sel_cfg),
    .cpu_addr  (ptr),
    .cpu_wdata,
    .rd_word   (mem_rd_word)
  );

  tti_cpu_regs u_regs (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_sel_cfg,
    .wr_ptr  (cpu_wdata[CFG_PTR_LSB +: WA_W]),
    .wr_inv  (cpu_wdata[CFG_INV_BIT]),
    .wr_auto (cpu_wdata[CFG_AUTO_BIT]),
    .wr_manu (cpu_wdata[CFG_MANU_BIT]),
    .mem_rd_word, .ptr, .inv_pulse, .auto_en, .manu_en,
    .cpu_rvalid, .cpu_rdata
  );

  assign force_biae = manu_en || (auto_en && iae_det);
  assign bei_out    = force_biae ? BIAE_CODE : bei_in;

  p_manual_biae_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_sel_cfg && cpu_wdata[CFG_MANU_BIT]) |=> (bei_out == BIAE_CODE));
endmodule

// File: tb/tti_capture_buf_tb.sv
module tti_capture_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ov_valid = 1'b0, ov_ready;
  logic [7:0]  ov_byte = '0;
  logic [5:0]  ov_mfas = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_sel_cfg = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [15:0] cpu_rdata;
  logic        iae_det = 1'b0;
  logic [3:0]  bei_in = 4'h5, bei_out;
  logic [2:0]  tti_live;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] cfg_sh = '0;

  always #5 clk = ~clk;

  tti_capture_buf dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 37 + seed * 11 + 3) ^ (i << 2));
  endfunction

  task automatic feed_mf(int seed, int skip);
    for (int i = 0; i < 64; i++) begin
      if (i == skip) continue;
      @(negedge clk);
      ov_valid = 1'b1; ov_byte = pat(i, seed); ov_mfas = 6'(i);
      if (ov_ready !== 1'b1) chk("R13 ready", ov_ready, 1);
    end
    @(negedge clk);
    ov_valid = 1'b0;
  endtask

  task automatic cpu_op(bit we, bit cfg, logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_sel_cfg = cfg; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (!we) chk("R4 rvalid", cpu_rvalid, 1);
    rd = cpu_rdata;
    if (we && cfg) cfg_sh = wd;
  endtask

  task automatic cfg_wr(logic [15:0] v);
    logic [15:0] d;
    cpu_op(1, 1, v, d);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    cpu_op(0, 1, 16'h0, d);
    chk("R1 cfg", d, 16'h0000);
    chk("R1 live", tti_live, 3'b000);
    chk("R1 bei", bei_out, bei_in);
    chk("R13 ready", ov_ready, 1);
  endtask

  task automatic t_layout;
    logic [15:0] d;
    feed_mf(1, -1);
    chk("R9 live", tti_live, 3'b111);
    for (int w = 0; w < 32; w++) begin
      cpu_op(0, 0, 16'h0, d);
      chk("R2 word", d, {pat(2*w+1, 1), pat(2*w, 1)});
    end
    cpu_op(0, 1, 16'h0, d);
    chk("R5 wrap", d[12:8], 5'd0);
  endtask

  task automatic t_overwrite;
    logic [15:0] d;
    feed_mf(2, -1);
    cfg_wr(16'h0700);
    for (int w = 7; w < 10; w++) begin
      cpu_op(0, 0, 16'h0, d);
      chk("R3 overwrite", d, {pat(2*w+1, 2), pat(2*w, 2)});
    end
  endtask

  task automatic t_cpu_write;
    logic [15:0] d;
    cfg_wr(16'h1E00);
    for (int k = 0; k < 3; k++) cpu_op(1, 0, 16'hC0DE + 16'(k), d);
    cpu_op(0, 1, 16'h0, d);
    chk("R5 ptr after wrap", d[12:8], 5'd1);
    cfg_wr(16'h1E00);
    for (int k = 0; k < 3; k++) begin
      cpu_op(0, 0, 16'h0, d);
      chk("R6 rdback", d, 16'hC0DE + 16'(k));
    end
  endtask

  task automatic t_cfg_layout;
    logic [15:0] d;
    feed_mf(3, -1);
    cfg_wr(16'hFFFF);
    chk("R8 live cleared", tti_live, 3'b000);
    cpu_op(0, 1, 16'h0, d);
    chk("R7 layout", d, 16'h1FB0);
    cfg_wr(16'h0000);
    cpu_op(0, 1, 16'h0, d);
    chk("R7 cleared", d, 16'h0000);
  endtask

  task automatic t_invalidate;
    feed_mf(4, -1);
    chk("R9 live", tti_live, 3'b111);
    cfg_wr(16'h0080);
    chk("R8 edge", tti_live, 3'b000);
    feed_mf(5, -1);
    chk("R9 refill", tti_live, 3'b111);
    cfg_wr(16'h0080);
    chk("R8 no edge", tti_live, 3'b111);
    cfg_wr(16'h0000);
  endtask

  task automatic t_gap;
    cfg_wr(16'h0080);
    chk("R8 edge", tti_live, 3'b000);
    feed_mf(6, 20);
    chk("R9 gap", tti_live, 3'b000);
    feed_mf(6, -1);
    chk("R9 after gap", tti_live, 3'b111);
    cfg_wr(16'h0000);
  endtask

  task automatic t_biae;
    bei_in = 4'h3;
    cfg_wr(16'h0020);
    iae_det = 1'b0; #1;
    chk("R10 auto idle", bei_out, 4'h3);
    iae_det = 1'b1; #1;
    chk("R10 auto iae", bei_out, 4'b1011);
    cfg_wr(16'h0000);
    chk("R10 disabled", bei_out, 4'h3);
    iae_det = 1'b0;
    cfg_wr(16'h0010);
    chk("R11 manual", bei_out, 4'b1011);
    iae_det = 1'b1; #1;
    chk("R11 manual iae", bei_out, 4'b1011);
    iae_det = 1'b0;
    cfg_wr(16'h0000);
    chk("R11 off", bei_out, 4'h3);
  endtask

  task automatic t_collision;
    logic [15:0] d;
    cfg_wr(16'h0500);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_sel_cfg = 1'b0; cpu_wdata = 16'hAAAA;
    ov_valid = 1'b1; ov_mfas = 6'd10; ov_byte = 8'h3C;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; ov_valid = 1'b0;
    cfg_wr(16'h0500);
    cpu_op(0, 0, 16'h0, d);
    chk("R12 collision", d, 16'hAA3C);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_overwrite();
    t_cpu_write();
    t_cfg_layout();
    t_invalidate();
    t_gap();
    t_biae();
    t_collision();
    finish_run();
  end
endmodule